// File: doc/BRIEF.md
# Fetch/Execute Sequencing Controller

This block is the control state machine of a single-issue, non-pipelined core. It takes one instruction at a time through address translation, an instruction memory request, the fetch response, an execute step and, for loads and stores, a data memory request and response. Both memory ports use a request/accept/retry handshake. If a port rejects a request, the controller parks in that port's retry state until the port strobes retry. A negatively acknowledged response makes the controller send the same request again. The datapath, the caches and the translation unit sit outside the block. They report to it through single-cycle strobes and flags.

Outside logic can start the core after a delay it chooses, suspend it at an instruction boundary, or drain it. A drain takes effect at once when no memory access is in flight. Otherwise it takes effect when the pending response returns, and no further fetch starts. After a drain the controller parks in a switched-out state until the next reset. The controller also counts every cycle spent outside the idle and switched-out states.

Top module: `fx_sequencer`

## Requirements
- R1: After a synchronous reset, `state_o` reads Idle (code 0), all request strobes and pulses are low and `busy_cycles_o` is 0.
- R2: `activate_i` in Idle moves to Running (code 1) with the delay loaded from `act_delay_i`. Running then spends that many extra cycles before it enters TranslationWait (code 2). `activate_i` has no effect in any other state.
- R3: In TranslationWait, `xlat_done_i` without `xlat_fault_i` leads to FetchSend (code 3), where `imem_req_o` is high. If the port does not accept, the next state is FetchRetry (code 4), which holds without a request until `imem_retry_i` returns it to FetchSend. If the port accepts, the next state is FetchWait (code 5).
- R4: A response that arrives with its nack flag set, in FetchWait or DataWait (code 9), returns the controller to that port's send state (code 3 or 7) so the request is resent.
- R5: A good fetch response leads to Execute (code 6). If `exec_mem_i` and `exec_fault_i` are both low there, the next cycle shows `pc_adv_o` high and Running, and a new fetch follows.
- R6: `exec_mem_i` in Execute leads to DataSend (code 7, `dmem_req_o` high). The data port follows the same pattern as R3, with DataRetry (code 8) and DataWait (code 9). A good data response completes the instruction with a `pc_adv_o` pulse.
- R7: A translation fault, or `exec_fault_i` in Execute, moves the controller to Faulting (code 10) with a one-cycle `redirect_o` and no memory request. Faulting lasts one cycle, after which the controller returns to Running and fetches from the handler.
- R8: `suspend_i` in Running gives Idle on the next cycle. `suspend_i` seen during an instruction gives Idle once that instruction completes, with no new fetch. `suspend_i` in Idle has no effect.
- R9: `drain_req_i` in Idle, Running or SwitchedOut (code 11) gives a `drained_o` pulse on the next cycle, and the state becomes SwitchedOut. In any other state the controller goes to SwitchedOut with `drained_o` only when the pending fetch response returns or the instruction completes.
- R10: `busy_cycles_o` increases by one for every clock cycle whose state is neither Idle nor SwitchedOut.
- R11: `pc_adv_o`, `redirect_o` and `drained_o` change in the same cycle as the state transition they belong to. `pc_adv_o` and `redirect_o` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| activate_i | input | 1 | Start the core (honoured in Idle only) |
| act_delay_i | input | DLY_W | Extra Running cycles before the first fetch |
| suspend_i | input | 1 | Stop at the next instruction boundary |
| drain_req_i | input | 1 | Request a drain |
| xlat_done_i | input | 1 | Fetch translation finished |
| xlat_fault_i | input | 1 | Translation faulted (qualifies xlat_done_i) |
| exec_mem_i | input | 1 | Instruction in Execute references memory |
| exec_fault_i | input | 1 | Execute raised a fault |
| imem_req_o | output | 1 | Instruction port request |
| imem_accept_i | input | 1 | Instruction port accepts the request |
| imem_retry_i | input | 1 | Instruction port may be retried |
| imem_resp_i | input | 1 | Instruction response valid |
| imem_nack_i | input | 1 | Instruction response is a nack |
| dmem_req_o | output | 1 | Data port request |
| dmem_accept_i | input | 1 | Data port accepts the request |
| dmem_retry_i | input | 1 | Data port may be retried |
| dmem_resp_i | input | 1 | Data response valid |
| dmem_nack_i | input | 1 | Data response is a nack |
| state_o | output | 4 | Current state code |
| drained_o | output | 1 | Drain completed pulse |
| pc_adv_o | output | 1 | Instruction completed, PC advanced |
| redirect_o | output | 1 | PC redirected to the fault handler |
| busy_cycles_o | output | CNT_W | Count of non-idle cycles |

## Verification
The checker assumes that every strobe from the environment arrives only in the state that waits for it. That means `xlat_done_i` in TranslationWait, a retry strobe in that port's retry state, and a response in that port's wait state. The random stimulus keeps to this by reading the bench's own predicted state before it raises any of those strobes. Accept, activate, suspend, drain and the execute flags are left free in every cycle, so the tests also cover the cases where the block must ignore them.

// File: rtl/fx_pkg.sv
package fx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_RUN    = 4'd1,
    ST_XLAT   = 4'd2,
    ST_ISEND  = 4'd3,
    ST_IRETRY = 4'd4,
    ST_IWAIT  = 4'd5,
    ST_EXEC   = 4'd6,
    ST_DSEND  = 4'd7,
    ST_DRETRY = 4'd8,
    ST_DWAIT  = 4'd9,
    ST_FAULT  = 4'd10,
    ST_SWOUT  = 4'd11
  } fx_state_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RUN, PH_XLAT, PH_IFETCH, PH_EXEC, PH_DATA, PH_FAULT, PH_SWOUT
  } fx_phase_e;

  typedef enum logic [1:0] {
    PS_IDLE, PS_SEND, PS_RETRY, PS_WAIT
  } fx_port_e;

  localparam int NPORT = 2;
  localparam int PIDX_I = 0;
  localparam int PIDX_D = 1;

endpackage

// File: rtl/fx_port_ctl.sv
module fx_port_ctl
  import fx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start_i,
  input  logic     accept_i,
  input  logic     retry_i,
  input  logic     resp_i,
  input  logic     nack_i,
  output logic     req_o,
  output fx_port_e sub_o,
  output logic     done_o
);

  fx_port_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_IDLE:  if (start_i) st_d = PS_SEND;
      PS_SEND:  st_d = accept_i ? PS_WAIT : PS_RETRY;
      PS_RETRY: if (retry_i) st_d = PS_SEND;
      PS_WAIT:  if (resp_i) st_d = nack_i ? PS_SEND : PS_IDLE;
      default:  st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= PS_IDLE;
    else     st_q <= st_d;
  end

  assign req_o  = (st_q == PS_SEND);
  assign sub_o  = st_q;
  assign done_o = (st_q == PS_WAIT) && resp_i && !nack_i;

endmodule

// File: rtl/fx_busy_ctr.sv
module fx_busy_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (busy_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer
  import fx_pkg::*;
#(
  parameter int DLY_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             activate_i,
  input  logic [DLY_W-1:0] act_delay_i,
  input  logic             suspend_i,
  input  logic             drain_req_i,
  input  logic             xlat_done_i,
  input  logic             xlat_fault_i,
  input  logic             exec_mem_i,
  input  logic             exec_fault_i,
  output logic             imem_req_o,
  input  logic             imem_accept_i,
  input  logic             imem_retry_i,
  input  logic             imem_resp_i,
  input  logic             imem_nack_i,
  output logic             dmem_req_o,
  input  logic             dmem_accept_i,
  input  logic             dmem_retry_i,
  input  logic             dmem_resp_i,
  input  logic             dmem_nack_i,
  output logic [3:0]       state_o,
  output logic             drained_o,
  output logic             pc_adv_o,
  output logic             redirect_o,
  output logic [CNT_W-1:0] busy_cycles_o
);

  // per-port handshake engines
  logic [NPORT-1:0] p_start, p_acc, p_rty, p_rsp, p_nak, p_req, p_done;
  fx_port_e         p_sub [NPORT];

  assign p_acc = {dmem_accept_i, imem_accept_i};
  assign p_rty = {dmem_retry_i,  imem_retry_i};
  assign p_rsp = {dmem_resp_i,   imem_resp_i};
  assign p_nak = {dmem_nack_i,   imem_nack_i};

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    fx_port_ctl u_port (
      .clk      (clk),
      .rst      (rst),
      .start_i  (p_start[g]),
      .accept_i (p_acc[g]),
      .retry_i  (p_rty[g]),
      .resp_i   (p_rsp[g]),
      .nack_i   (p_nak[g]),
      .req_o    (p_req[g]),
      .sub_o    (p_sub[g]),
      .done_o   (p_done[g])
    );
  end

  assign imem_req_o = p_req[PIDX_I];
  assign dmem_req_o = p_req[PIDX_D];

  // main sequencing state
  fx_phase_e        ph_q, ph_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             drn_q, drn_d, sus_q, sus_d;
  logic             drained_d, adv_d, red_d;
  logic             drn_eff, sus_eff, finish;

  assign drn_eff = drn_q | drain_req_i;
  assign sus_eff = sus_q | suspend_i;

  assign p_start[PIDX_I] = (ph_q == PH_XLAT) && xlat_done_i && !xlat_fault_i;
  assign p_start[PIDX_D] = (ph_q == PH_EXEC) && exec_mem_i && !exec_fault_i;

  always_comb begin
    ph_d      = ph_q;
    dly_d     = dly_q;
    drained_d = 1'b0;
    adv_d     = 1'b0;
    red_d     = 1'b0;
    finish    = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (drain_req_i) begin
          ph_d      = PH_SWOUT;
          drained_d = 1'b1;
        end else if (activate_i) begin
          ph_d  = PH_RUN;
          dly_d = act_delay_i;
        end
      end
      PH_RUN: begin
        if (drn_eff) begin
          ph_d      = PH_SWOUT;
          drained_d = 1'b1;
        end else if (sus_eff) begin
          ph_d = PH_IDLE;
        end else if (dly_q != '0) begin
          dly_d = dly_q - DLY_W'(1);
        end else begin
          ph_d = PH_XLAT;
        end
      end
      PH_XLAT: begin
        if (xlat_done_i) begin
          if (xlat_fault_i) begin
            ph_d  = PH_FAULT;
            red_d = 1'b1;
          end else begin
            ph_d = PH_IFETCH;
          end
        end
      end
      PH_IFETCH: begin
        if (p_done[PIDX_I]) begin
          if (drn_eff) begin
            ph_d      = PH_SWOUT;
            drained_d = 1'b1;
          end else begin
            ph_d = PH_EXEC;
          end
        end
      end
      PH_EXEC: begin
        if (exec_fault_i) begin
          ph_d  = PH_FAULT;
          red_d = 1'b1;
        end else if (exec_mem_i) begin
          ph_d = PH_DATA;
        end else begin
          adv_d  = 1'b1;
          finish = 1'b1;
        end
      end
      PH_DATA: begin
        if (p_done[PIDX_D]) begin
          adv_d  = 1'b1;
          finish = 1'b1;
        end
      end
      PH_FAULT: finish = 1'b1;
      PH_SWOUT: drained_d = drain_req_i;
      default:  ph_d = PH_IDLE;
    endcase

    if (finish) begin
      if (drn_eff) begin
        ph_d      = PH_SWOUT;
        drained_d = 1'b1;
      end else if (sus_eff) begin
        ph_d = PH_IDLE;
      end else begin
        ph_d  = PH_RUN;
        dly_d = '0;
      end
    end

    drn_d = (ph_d == PH_IDLE || ph_d == PH_SWOUT) ? 1'b0 : drn_eff;
    sus_d = (ph_d == PH_IDLE || ph_d == PH_SWOUT || ph_q == PH_IDLE) ? 1'b0 : sus_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_IDLE;
      dly_q      <= '0;
      drn_q      <= 1'b0;
      sus_q      <= 1'b0;
      drained_o  <= 1'b0;
      pc_adv_o   <= 1'b0;
      redirect_o <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      dly_q      <= dly_d;
      drn_q      <= drn_d;
      sus_q      <= sus_d;
      drained_o  <= drained_d;
      pc_adv_o   <= adv_d;
      redirect_o <= red_d;
    end
  end

  // flat state code from phase and port sub-state
  fx_state_e st_flat;
  always_comb begin
    unique case (ph_q)
      PH_IDLE:   st_flat = ST_IDLE;
      PH_RUN:    st_flat = ST_RUN;
      PH_XLAT:   st_flat = ST_XLAT;
      PH_IFETCH: st_flat = (p_sub[PIDX_I] == PS_RETRY) ? ST_IRETRY :
                           (p_sub[PIDX_I] == PS_WAIT)  ? ST_IWAIT  : ST_ISEND;
      PH_EXEC:   st_flat = ST_EXEC;
      PH_DATA:   st_flat = (p_sub[PIDX_D] == PS_RETRY) ? ST_DRETRY :
                           (p_sub[PIDX_D] == PS_WAIT)  ? ST_DWAIT  : ST_DSEND;
      PH_FAULT:  st_flat = ST_FAULT;
      PH_SWOUT:  st_flat = ST_SWOUT;
      default:   st_flat = ST_IDLE;
    endcase
  end
  assign state_o = st_flat;

  fx_busy_ctr #(.CNT_W(CNT_W)) u_busy (
    .clk    (clk),
    .rst    (rst),
    .busy_i (ph_q != PH_IDLE && ph_q != PH_SWOUT),
    .cnt_o  (busy_cycles_o)
  );

endmodule

// File: rtl/fx_sequencer_chk.sv
module fx_sequencer_chk
  import fx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             activate_i,
  input logic             drain_req_i,
  input logic             xlat_done_i,
  input logic             xlat_fault_i,
  input logic             imem_accept_i,
  input logic             imem_retry_i,
  input logic             imem_req_o,
  input logic             dmem_req_o,
  input logic [3:0]       state_o,
  input logic             drained_o,
  input logic             pc_adv_o,
  input logic             redirect_o,
  input logic [CNT_W-1:0] busy_cycles_o
);

  assert_single_req_R3: assert property (@(posedge clk) disable iff (rst)
    !(imem_req_o && dmem_req_o));

  assert_retry_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_IRETRY && !imem_retry_i) |=> (state_o == ST_IRETRY && !imem_req_o));

  assert_accept_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_ISEND && imem_accept_i) |=> state_o == ST_IWAIT);

  assert_xlat_fault_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_XLAT && xlat_done_i && xlat_fault_i)
      |=> (state_o == ST_FAULT && redirect_o && !imem_req_o));

  assert_fault_leave_R7: assert property (@(posedge clk) disable iff (rst)
    state_o == ST_FAULT |=> state_o inside {ST_RUN, ST_IDLE, ST_SWOUT});

  assert_drained_swout_R9: assert property (@(posedge clk) disable iff (rst)
    drained_o |-> state_o == ST_SWOUT);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_IDLE && !activate_i && !drain_req_i) |=> state_o == ST_IDLE);

  assert_count_R10: assert property (@(posedge clk) disable iff (rst)
    (state_o != ST_IDLE && state_o != ST_SWOUT)
      |=> busy_cycles_o == $past(busy_cycles_o) + CNT_W'(1));

  assert_adv_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    pc_adv_o |=> !pc_adv_o);

endmodule

bind fx_sequencer fx_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .activate_i    (activate_i),
  .drain_req_i   (drain_req_i),
  .xlat_done_i   (xlat_done_i),
  .xlat_fault_i  (xlat_fault_i),
  .imem_accept_i (imem_accept_i),
  .imem_retry_i  (imem_retry_i),
  .imem_req_o    (imem_req_o),
  .dmem_req_o    (dmem_req_o),
  .state_o       (state_o),
  .drained_o     (drained_o),
  .pc_adv_o      (pc_adv_o),
  .redirect_o    (redirect_o),
  .busy_cycles_o (busy_cycles_o)
);

// File: tb/fx_sequencer_bench.sv
`timescale 1ns/1ps
module fx_sequencer_bench;

  localparam int DLY_W = 4;
  localparam int CNT_W = 16;
  localparam int RUNS  = 6;
  localparam int STEPS = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             act, sus, drn, xd, xf, em, ef;
  logic [DLY_W-1:0] adl;
  logic             ia, ir, irs, ink, da, dr, drs, dnk;
  logic             imem_req, dmem_req, drained, pc_adv, redirect;
  logic [3:0]       state;
  logic [CNT_W-1:0] busy;

  fx_sequencer #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_fx_sequencer (
    .clk(clk), .rst(rst), .activate_i(act), .act_delay_i(adl),
    .suspend_i(sus), .drain_req_i(drn), .xlat_done_i(xd), .xlat_fault_i(xf),
    .exec_mem_i(em), .exec_fault_i(ef),
    .imem_req_o(imem_req), .imem_accept_i(ia), .imem_retry_i(ir),
    .imem_resp_i(irs), .imem_nack_i(ink),
    .dmem_req_o(dmem_req), .dmem_accept_i(da), .dmem_retry_i(dr),
    .dmem_resp_i(drs), .dmem_nack_i(dnk),
    .state_o(state), .drained_o(drained), .pc_adv_o(pc_adv),
    .redirect_o(redirect), .busy_cycles_o(busy)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bench model of the requirements
  int m_st, m_dly, m_cnt;
  bit m_dr, m_sp, e_drn, e_adv, e_red;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int actv, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, actv, expv);
    end
  endtask

  task automatic clr_in();
    act = 0; adl = '0; sus = 0; drn = 0; xd = 0; xf = 0; em = 0; ef = 0;
    ia = 0; ir = 0; irs = 0; ink = 0; da = 0; dr = 0; drs = 0; dnk = 0;
  endtask

  task automatic model_reset();
    m_st = 0; m_dly = 0; m_cnt = 0; m_dr = 0; m_sp = 0;
    e_drn = 0; e_adv = 0; e_red = 0;
  endtask

  task automatic model_step();
    int ns;
    bit fdr, fsp, fin;
    ns = m_st; fdr = m_dr | drn; fsp = m_sp | sus; fin = 0;
    e_drn = 0; e_adv = 0; e_red = 0;
    if (m_st != 0 && m_st != 11) m_cnt++;
    case (m_st)
      0:  if (drn) begin ns = 11; e_drn = 1; end
          else if (act) begin ns = 1; m_dly = int'(adl); end
      1:  if (fdr) begin ns = 11; e_drn = 1; end
          else if (fsp) ns = 0;
          else if (m_dly != 0) m_dly--;
          else ns = 2;
      2:  if (xd) begin if (xf) begin ns = 10; e_red = 1; end else ns = 3; end
      3:  ns = ia ? 5 : 4;
      4:  if (ir) ns = 3;
      5:  if (irs) begin
            if (ink) ns = 3;
            else if (fdr) begin ns = 11; e_drn = 1; end
            else ns = 6;
          end
      6:  if (ef) begin ns = 10; e_red = 1; end
          else if (em) ns = 7;
          else begin e_adv = 1; fin = 1; end
      7:  ns = da ? 9 : 8;
      8:  if (dr) ns = 7;
      9:  if (drs) begin if (dnk) ns = 7; else begin e_adv = 1; fin = 1; end end
      10: fin = 1;
      11: e_drn = drn;
      default: ns = 0;
    endcase
    if (fin) begin
      if (fdr) begin ns = 11; e_drn = 1; end
      else if (fsp) ns = 0;
      else begin ns = 1; m_dly = 0; end
    end
    m_dr = (ns == 0 || ns == 11) ? 1'b0 : fdr;
    m_sp = (ns == 0 || ns == 11 || m_st == 0) ? 1'b0 : fsp;
    m_st = ns;
  endtask

  function automatic string tag_of(input int s);
    case (s)
      0, 1:    return "R2";
      2, 10:   return "R7";
      3, 4:    return "R3";
      5:       return "R4";
      6:       return "R5";
      7, 8, 9: return "R6";
      default: return "R9";
    endcase
  endfunction

  // inputs are already driven; one clock, then compare at the falling edge
  task automatic step(input string tag);
    model_step();
    @(negedge clk);
    chk(int'(state) == m_st, tag, "state", int'(state), m_st);
    chk(imem_req == (m_st == 3), tag, "imem_req", int'(imem_req), int'(m_st == 3));
    chk(dmem_req == (m_st == 7), tag, "dmem_req", int'(dmem_req), int'(m_st == 7));
    chk(drained == e_drn, "R11", "drained", int'(drained), int'(e_drn));
    chk(pc_adv == e_adv, "R11", "pc_adv", int'(pc_adv), int'(e_adv));
    chk(redirect == e_red, "R11", "redirect", int'(redirect), int'(e_red));
    chk(int'(busy) == (m_cnt % 65536), "R10", "busy_cycles", int'(busy), m_cnt % 65536);
    clr_in();
  endtask

  task automatic do_reset();
    rst = 1; clr_in();
    @(negedge clk); @(negedge clk);
    rst = 0; model_reset();
    chk(state == 4'd0, "R1", "reset state", int'(state), 0);
    chk(!imem_req && !dmem_req, "R1", "reset requests", int'(imem_req | dmem_req), 0);
    chk(!drained && !pc_adv && !redirect, "R1", "reset pulses",
        int'(drained | pc_adv | redirect), 0);
    chk(busy == '0, "R1", "reset counter", int'(busy), 0);
  endtask

  task automatic expect_state(input int s, input string tag);
    chk(int'(state) == s, tag, "directed state", int'(state), s);
  endtask

  task automatic random_run();
    int idle_sw = 0;
    for (int k = 0; k < STEPS; k++) begin
      string t;
      t = tag_of(m_st);
      act = ($urandom % 4) == 0;
      adl = DLY_W'($urandom % 4);
      sus = ($urandom % 40) == 0;
      drn = ($urandom % 150) == 0;
      em  = ($urandom % 2) == 0;
      ef  = ($urandom % 8) == 0;
      ia  = ($urandom % 3) != 0;
      da  = ($urandom % 3) != 0;
      if (m_st == 2) begin xd = ($urandom % 2) == 0; xf = ($urandom % 6) == 0; end
      if (m_st == 4) ir  = ($urandom % 2) == 0;
      if (m_st == 8) dr  = ($urandom % 2) == 0;
      if (m_st == 5) begin irs = ($urandom % 3) == 0; ink = ($urandom % 4) == 0; end
      if (m_st == 9) begin drs = ($urandom % 3) == 0; dnk = ($urandom % 4) == 0; end
      step(t);
      idle_sw = (m_st == 11) ? idle_sw + 1 : 0;
      if (idle_sw > 3) break;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1417));
    clr_in();
    do_reset();

    // R2: start with a delay of two; activate while running is ignored
    act = 1; adl = 4'd2; step("R2"); expect_state(1, "R2");
    act = 1; adl = 4'd9; step("R2"); expect_state(1, "R2");
    step("R2"); expect_state(1, "R2");
    step("R2"); expect_state(2, "R2");
    // R3: reject, hold, retry, accept
    xd = 1; step("R3"); expect_state(3, "R3");
    step("R3"); expect_state(4, "R3");
    step("R3"); expect_state(4, "R3");
    ir = 1; step("R3"); expect_state(3, "R3");
    ia = 1; step("R3"); expect_state(5, "R3");
    // R4: nack resends
    irs = 1; ink = 1; step("R4"); expect_state(3, "R4");
    ia = 1; step("R4");
    irs = 1; step("R5"); expect_state(6, "R5");
    // R5: non-memory instruction completes
    step("R5"); expect_state(1, "R5");
    step("R5"); expect_state(2, "R5");
    // R7: translation fault
    xd = 1; xf = 1; step("R7"); expect_state(10, "R7");
    step("R7"); expect_state(1, "R7");
    step("R7");
    xd = 1; step("R6"); ia = 1; step("R6"); irs = 1; step("R6");
    // R6: data access with reject, retry, nack
    em = 1; step("R6"); expect_state(7, "R6");
    step("R6"); expect_state(8, "R6");
    dr = 1; step("R6"); expect_state(7, "R6");
    da = 1; step("R6"); expect_state(9, "R6");
    drs = 1; dnk = 1; step("R4"); expect_state(7, "R4");
    da = 1; step("R6");
    drs = 1; step("R6"); expect_state(1, "R6");
    step("R6");
    // R8: suspend during an instruction, then in Idle
    xd = 1; sus = 1; step("R8");
    ia = 1; step("R8"); irs = 1; step("R8");
    step("R8"); expect_state(0, "R8");
    sus = 1; step("R8"); expect_state(0, "R8");
    act = 1; step("R8");
    sus = 1; step("R8"); expect_state(0, "R8");
    // R9: drain while a fetch is in flight
    act = 1; step("R9"); step("R9");
    drn = 1; step("R9"); expect_state(2, "R9");
    xd = 1; step("R9"); ia = 1; step("R9");
    irs = 1; step("R9"); expect_state(11, "R9");
    drn = 1; step("R9"); expect_state(11, "R9");
    // R9: drain in Idle and in Running
    do_reset(); drn = 1; step("R9"); expect_state(11, "R9");
    do_reset(); act = 1; step("R9"); drn = 1; step("R9"); expect_state(11, "R9");
    // R7 with R9: execute fault while draining
    do_reset(); act = 1; step("R7"); step("R7");
    xd = 1; step("R7"); ia = 1; step("R7"); irs = 1; step("R7");
    ef = 1; drn = 1; step("R7"); expect_state(10, "R7");
    step("R9"); expect_state(11, "R9");

    for (int r = 0; r < RUNS; r++) begin
      do_reset();
      random_run();
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule